// File: doc/BRIEF.md
# SPI Slave Serial Front-End with Hold Pause

This block is the pin-side front end of a flash-style SPI slave. A fast system clock samples the chip-select, serial-clock, hold and data-in pins through synchronizers. Edge detection on the synchronized serial clock drives the datapath. Received bits are shifted in MSB first on serial-clock rising edges. Each completed byte is reported with a one-cycle strobe. The output bit advances on serial-clock falling edges, from a transmit byte that the surrounding logic presents on a parallel port. The block assumes serial clock mode 0, with the clock idle low.

A hold pin pauses a transaction without ending it. A pause begins or ends only while the serial clock is low. A request made while the clock is high waits for the next low phase, and it is dropped if the hold pin returns to its former level first. During a pause the output enable is off, and clock and data activity on the pins is ignored. Deselecting the device clears the whole front end, including a pause in progress. A selection made while hold is still low is refused until the next deselect, so a stale hold level can never start a new pause. A busy flag from the internal write engine passes straight through, and the hold logic never touches it.

The control is a six-state machine:
- ST_DESEL: the device is deselected. The datapath is cleared and the transmit byte is loaded continuously.
- ST_BLOCKED: the device was selected while hold was low. The block stays inert until deselected.
- ST_ACTIVE: a normal transfer is running.
- ST_ENTER_PEND: hold fell while the serial clock was high, and the transfer still runs.
- ST_HOLD: the transfer is paused.
- ST_EXIT_PEND: hold rose while the serial clock was high, and the transfer is still paused.

The transitions are:
- Chip select high sends any state to ST_DESEL.
- ST_DESEL goes to ST_ACTIVE when selected with hold high, or to ST_BLOCKED when selected with hold low.
- ST_ACTIVE goes to ST_HOLD when hold falls with the clock low, or to ST_ENTER_PEND when hold falls with the clock high.
- ST_ENTER_PEND goes to ST_HOLD when the clock goes low, or back to ST_ACTIVE if hold rises first (cancel).
- ST_HOLD goes to ST_ACTIVE when hold rises with the clock low, or to ST_EXIT_PEND when hold rises with the clock high.
- ST_EXIT_PEND goes to ST_ACTIVE when the clock goes low, or back to ST_HOLD if hold falls first (cancel).

Top module: `spi_hold_frontend`

## Requirements
- R1: Data-in is captured on each serial-clock rising edge, MSB first. After every eighth rising edge, rx_byte holds the assembled byte and rx_valid is high for exactly one system clock.
- R2: When selected, miso_out shows bit 7 of tx_byte. Each serial-clock falling edge advances it one bit toward bit 0. tx_byte is captured again at the eighth rising edge, and its bit 7 appears after the following falling edge.
- R3: miso_oe is high only while chip select is low and no pause is in effect. It is low while deselected, while blocked and while in hold.
- R4: A hold falling edge that arrives while the serial clock is low starts the pause at once (hold_active goes high and miso_oe goes low).
- R5: A hold falling edge that arrives while the serial clock is high leaves hold_active low and miso_oe high until the serial clock next goes low. The pause then starts.
- R6: A hold rising edge ends the pause at once if the serial clock is low. Otherwise hold_active stays high until the serial clock next goes low.
- R7: If hold returns high before the serial clock goes low, a pending entry is cancelled. No pause occurs and the transfer is unaffected.
- R8: During a pause, serial-clock and data-in activity is ignored. The bit count and both shift registers keep their values, so the byte resumes where it stopped.
- R9: Chip select high clears the bit count, the shift registers and any pause. A later transfer starts again at bit 7.
- R10: A selection made while hold is low neither pauses nor transfers. miso_oe and hold_active stay low and rx_valid never pulses, until a deselect.
- R11: busy_out equals busy_in at all times, including during a pause.
- R12: After reset, miso_oe, hold_active and rx_valid are 0 and rx_byte is 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock, at least four times the serial clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cs_n_pin | input | 1 | Chip select pin, active low |
| sclk_pin | input | 1 | Serial clock pin |
| hold_n_pin | input | 1 | Hold pin, active low |
| mosi_pin | input | 1 | Serial data-in pin |
| tx_byte | input | DATA_W | Next byte to transmit |
| busy_in | input | 1 | Busy flag from the internal write engine |
| rx_byte | output | DATA_W | Last completed received byte |
| rx_valid | output | 1 | One-cycle strobe when rx_byte updates |
| miso_out | output | 1 | Serial output bit |
| miso_oe | output | 1 | Output enable for the serial output pad |
| hold_active | output | 1 | High while a pause is in effect |
| busy_out | output | 1 | Busy flag passed through |

## Verification
A wrong control state shows up at the ports within one serial-clock half period. A missed or premature pause appears as hold_active and miso_oe flipping in the wrong clock phase. A bit count or shift register that is not frozen corrupts the very next rx_byte and the transmitted bits, and both are compared against expected values per byte. A stale hold level, or a reset that leaves state behind, shows as a spurious rx_valid, or as a byte that after reselection is misaligned against its expected MSB-first value.

// File: rtl/spi_fe_pkg.sv
package spi_fe_pkg;
    typedef enum logic [2:0] {
        ST_DESEL      = 3'd0,
        ST_BLOCKED    = 3'd1,
        ST_ACTIVE     = 3'd2,
        ST_ENTER_PEND = 3'd3,
        ST_HOLD       = 3'd4,
        ST_EXIT_PEND  = 3'd5
    } fe_state_t;
endpackage

// File: rtl/spi_fe_sync.sv
module spi_fe_sync #(
    parameter int              WIDTH   = 4,
    parameter int              STAGES  = 2,
    parameter logic [WIDTH-1:0] RST_VAL = '0
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] din,
    output logic [WIDTH-1:0] dout
);
    logic [WIDTH-1:0] pipe [STAGES];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < STAGES; i++) pipe[i] <= RST_VAL;
        end else begin
            pipe[0] <= din;
            for (int i = 1; i < STAGES; i++) pipe[i] <= pipe[i-1];
        end
    end

    assign dout = pipe[STAGES-1];
endmodule

// File: rtl/spi_fe_hold_ctrl.sv
module spi_fe_hold_ctrl
    import spi_fe_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic cs_s,
    input  logic sclk_s,
    input  logic hold_s,
    output logic shift_en,
    output logic clear,
    output logic oe,
    output logic hold_active
);
    fe_state_t state_q, state_d;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_DESEL;
        else        state_q <= state_d;
    end

    // transitions (hold_s is active high = pin high = not holding)
    always_comb begin
        state_d = state_q;
        if (cs_s) begin
            state_d = ST_DESEL;
        end else begin
            unique case (state_q)
                ST_DESEL:      state_d = hold_s ? ST_ACTIVE : ST_BLOCKED;
                ST_BLOCKED:    state_d = ST_BLOCKED;
                ST_ACTIVE:     if (!hold_s) state_d = sclk_s ? ST_ENTER_PEND : ST_HOLD;
                ST_ENTER_PEND: begin
                    if (hold_s)       state_d = ST_ACTIVE;
                    else if (!sclk_s) state_d = ST_HOLD;
                end
                ST_HOLD:       if (hold_s) state_d = sclk_s ? ST_EXIT_PEND : ST_ACTIVE;
                ST_EXIT_PEND: begin
                    if (!hold_s)      state_d = ST_HOLD;
                    else if (!sclk_s) state_d = ST_ACTIVE;
                end
                default:       state_d = ST_DESEL;
            endcase
        end
    end

    // outputs
    always_comb begin
        shift_en    = 1'b0;
        clear       = cs_s;
        oe          = 1'b0;
        hold_active = 1'b0;
        unique case (state_q)
            ST_DESEL, ST_BLOCKED: clear = 1'b1;
            ST_ACTIVE, ST_ENTER_PEND: begin
                shift_en = 1'b1;
                oe       = 1'b1;
            end
            ST_HOLD, ST_EXIT_PEND: hold_active = 1'b1;
            default: clear = 1'b1;
        endcase
    end
endmodule

// File: rtl/spi_fe_shifter.sv
module spi_fe_shifter #(
    parameter int DATA_W = 8,
    localparam int CNT_W = $clog2(DATA_W)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clear,
    input  logic              shift_en,
    input  logic              sclk_s,
    input  logic              mosi_s,
    input  logic [DATA_W-1:0] tx_byte,
    output logic [DATA_W-1:0] rx_byte,
    output logic              rx_valid,
    output logic              miso_bit,
    output logic [CNT_W-1:0]  bit_cnt
);
    localparam logic [CNT_W-1:0] LAST = CNT_W'(DATA_W - 1);

    logic              sclk_q;
    logic [DATA_W-1:0] rx_sh, tx_sh, tx_nxt, rx_next;
    logic              reload;
    logic              rise, fall;

    assign rise    = sclk_s & ~sclk_q;
    assign fall    = ~sclk_s & sclk_q;
    assign rx_next = {rx_sh[DATA_W-2:0], mosi_s};

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sclk_q   <= 1'b0;
            rx_sh    <= '0;
            tx_sh    <= '0;
            tx_nxt   <= '0;
            reload   <= 1'b0;
            bit_cnt  <= '0;
            rx_byte  <= '0;
            rx_valid <= 1'b0;
        end else begin
            sclk_q   <= sclk_s;
            rx_valid <= 1'b0;
            if (clear) begin
                rx_sh   <= '0;
                tx_sh   <= tx_byte;
                tx_nxt  <= '0;
                reload  <= 1'b0;
                bit_cnt <= '0;
            end else if (shift_en) begin
                if (rise) begin
                    rx_sh <= rx_next;
                    if (bit_cnt == LAST) begin
                        bit_cnt  <= '0;
                        rx_byte  <= rx_next;
                        rx_valid <= 1'b1;
                        tx_nxt   <= tx_byte;
                        reload   <= 1'b1;
                    end else begin
                        bit_cnt <= bit_cnt + 1'b1;
                    end
                end
                if (fall) begin
                    if (reload) begin
                        tx_sh  <= tx_nxt;
                        reload <= 1'b0;
                    end else begin
                        tx_sh <= {tx_sh[DATA_W-2:0], 1'b0};
                    end
                end
            end
        end
    end

    assign miso_bit = tx_sh[DATA_W-1];
endmodule

// File: rtl/spi_hold_frontend.sv
module spi_hold_frontend #(
    parameter int DATA_W    = 8,
    parameter int SYNC_STGS = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cs_n_pin,
    input  logic              sclk_pin,
    input  logic              hold_n_pin,
    input  logic              mosi_pin,
    input  logic [DATA_W-1:0] tx_byte,
    input  logic              busy_in,
    output logic [DATA_W-1:0] rx_byte,
    output logic              rx_valid,
    output logic              miso_out,
    output logic              miso_oe,
    output logic              hold_active,
    output logic              busy_out
);
    localparam int CNT_W = $clog2(DATA_W);

    logic [3:0]       pins_s;
    logic             cs_s, sclk_s, hold_s, mosi_s;
    logic             shift_en, clear;
    logic [CNT_W-1:0] bit_cnt;

    spi_fe_sync #(
        .WIDTH  (4),
        .STAGES (SYNC_STGS),
        .RST_VAL(4'b1010)
    ) u_sync (
        .clk (clk),
        .rst_n(rst_n),
        .din ({cs_n_pin, sclk_pin, hold_n_pin, mosi_pin}),
        .dout(pins_s)
    );

    assign {cs_s, sclk_s, hold_s, mosi_s} = pins_s;

    spi_fe_hold_ctrl u_ctrl (
        .clk        (clk),
        .rst_n      (rst_n),
        .cs_s       (cs_s),
        .sclk_s     (sclk_s),
        .hold_s     (hold_s),
        .shift_en   (shift_en),
        .clear      (clear),
        .oe         (miso_oe),
        .hold_active(hold_active)
    );

    spi_fe_shifter #(.DATA_W(DATA_W)) u_shift (
        .clk     (clk),
        .rst_n   (rst_n),
        .clear   (clear),
        .shift_en(shift_en),
        .sclk_s  (sclk_s),
        .mosi_s  (mosi_s),
        .tx_byte (tx_byte),
        .rx_byte (rx_byte),
        .rx_valid(rx_valid),
        .miso_bit(miso_out),
        .bit_cnt (bit_cnt)
    );

    // the write engine flag is never gated by hold
    assign busy_out = busy_in;
endmodule

// File: rtl/spi_fe_checker.sv
module spi_fe_checker #(
    parameter int CNT_W = 3
) (
    input logic             clk,
    input logic             rst_n,
    input logic             cs_s,
    input logic             sclk_s,
    input logic             hold_active,
    input logic             miso_oe,
    input logic             rx_valid,
    input logic [CNT_W-1:0] bit_cnt,
    input logic             busy_in,
    input logic             busy_out
);
    a_r1_valid_single: assert property (@(posedge clk) disable iff (!rst_n)
        rx_valid |=> !rx_valid);

    a_r3_oe_off_in_hold: assert property (@(posedge clk) disable iff (!rst_n)
        hold_active |-> !miso_oe);

    a_r4_enter_on_low: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(hold_active) |-> !$past(sclk_s));

    a_r6_exit_on_low: assert property (@(posedge clk) disable iff (!rst_n)
        ($fell(hold_active) && !$past(cs_s)) |-> !$past(sclk_s));

    a_r8_count_frozen: assert property (@(posedge clk) disable iff (!rst_n)
        (hold_active && !cs_s) |=> ($stable(bit_cnt) && !rx_valid));

    a_r9_desel_clears: assert property (@(posedge clk) disable iff (!rst_n)
        cs_s |=> (bit_cnt == '0 && !hold_active));

    a_r11_busy_through: assert property (@(posedge clk) disable iff (!rst_n)
        busy_out == busy_in);
endmodule

bind spi_hold_frontend spi_fe_checker #(.CNT_W(CNT_W)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .cs_s       (cs_s),
    .sclk_s     (sclk_s),
    .hold_active(hold_active),
    .miso_oe    (miso_oe),
    .rx_valid   (rx_valid),
    .bit_cnt    (bit_cnt),
    .busy_in    (busy_in),
    .busy_out   (busy_out)
);

// File: tb/test_spi_hold_frontend.sv
module test_spi_hold_frontend;
    logic       clk = 1'b0;
    logic       rst_n, cs_n, sclk, hold_n, mosi, busy_in;
    logic [7:0] tx_byte;
    logic [7:0] rx_byte;
    logic       rx_valid, miso_out, miso_oe, hold_active, busy_out;

    int         tests = 0, failed = 0, rx_count = 0;
    logic [7:0] exp_rx [$];
    logic [7:0] miso_acc;

    always #10 clk = ~clk;   // 50 MHz

    spi_hold_frontend i_spi_hold_frontend (
        .clk(clk), .rst_n(rst_n), .cs_n_pin(cs_n), .sclk_pin(sclk),
        .hold_n_pin(hold_n), .mosi_pin(mosi), .tx_byte(tx_byte),
        .busy_in(busy_in), .rx_byte(rx_byte), .rx_valid(rx_valid),
        .miso_out(miso_out), .miso_oe(miso_oe), .hold_active(hold_active),
        .busy_out(busy_out)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        tests++;
        if (act !== exp) begin
            failed++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic wclk(input int n);
        repeat (n) @(negedge clk);
    endtask

    // one serial bit: data set in low phase, output sampled before the rise
    task automatic bit_clk(input logic b);
        mosi = b;
        wclk(4);
        miso_acc = {miso_acc[6:0], miso_out};
        sclk = 1'b1;
        wclk(4);
        sclk = 1'b0;
    endtask

    task automatic select(input logic [7:0] first_tx);
        tx_byte = first_tx;
        wclk(2);
        cs_n = 1'b0;
        wclk(6);
    endtask

    task automatic deselect();
        wclk(4);
        cs_n = 1'b1;
        wclk(6);
        check("R3 oe after deselect", miso_oe, 1'b0);
    endtask

    // driver: pushes the expected received byte, checks transmitted bits
    task automatic send_byte(input logic [7:0] d, input logic [7:0] exp_miso, input logic [7:0] next_tx);
        exp_rx.push_back(d);
        tx_byte = next_tx;
        for (int i = 7; i >= 0; i--) bit_clk(d[i]);
        check("R2 miso byte", miso_acc, exp_miso);
    endtask

    // monitor: scoreboard compare on each strobe
    always @(negedge clk) begin
        if (rst_n && rx_valid) begin
            rx_count++;
            if (exp_rx.size() == 0) begin
                tests++;
                failed++;
                $display("FAIL R1 unexpected rx_valid actual=%0h expected=none", rx_byte);
            end else begin
                check("R1 rx_byte", rx_byte, exp_rx.pop_front());
            end
        end
    end

    initial begin
        repeat (200000) @(posedge clk);
        failed++;
        tests++;
        $display("FAIL watchdog actual=timeout expected=done");
        $display("  [TB] %0d tests run, %0d failed", tests, failed);
        $finish;
    end

    initial begin
        logic [7:0] d;
        int         rc;
        rst_n = 1'b0; cs_n = 1'b1; sclk = 1'b0; hold_n = 1'b1; mosi = 1'b0;
        busy_in = 1'b0; tx_byte = 8'h00; miso_acc = 8'h00;
        wclk(5);
        rst_n = 1'b1;
        wclk(2);
        check("R12 oe", miso_oe, 1'b0);
        check("R12 hold_active", hold_active, 1'b0);
        check("R12 rx_valid", rx_valid, 1'b0);
        check("R12 rx_byte", rx_byte, 8'h00);

        // plain two-byte transfer, reload of the transmit byte
        select(8'hA5);
        check("R3 oe when selected", miso_oe, 1'b1);
        send_byte(8'h3C, 8'hA5, 8'h5A);
        send_byte(8'hC3, 8'h5A, 8'h00);
        deselect();

        // immediate pause with clock low, junk clocks ignored
        select(8'h96);
        d = 8'hB2;
        exp_rx.push_back(d);
        for (int i = 7; i >= 4; i--) bit_clk(d[i]);
        hold_n = 1'b0;
        wclk(5);
        check("R4 hold entered", hold_active, 1'b1);
        check("R3 oe off in hold", miso_oe, 1'b0);
        busy_in = 1'b1;
        wclk(1);
        check("R11 busy in hold", busy_out, 1'b1);
        for (int k = 0; k < 3; k++) begin
            mosi = ~mosi;
            sclk = 1'b1; wclk(4);
            sclk = 1'b0; wclk(4);
        end
        hold_n = 1'b1;
        wclk(5);
        check("R6 exit with clock low", hold_active, 1'b0);
        check("R3 oe back", miso_oe, 1'b1);
        busy_in = 1'b0;
        wclk(1);
        check("R11 busy cleared", busy_out, 1'b0);
        for (int i = 3; i >= 0; i--) bit_clk(d[i]);
        check("R8 miso resumes", miso_acc, 8'h96);
        deselect();

        // deferred entry and deferred exit
        select(8'h3E);
        d = 8'h71;
        exp_rx.push_back(d);
        for (int i = 7; i >= 5; i--) bit_clk(d[i]);
        mosi = d[4];
        wclk(4);
        miso_acc = {miso_acc[6:0], miso_out};
        sclk = 1'b1;
        wclk(2);
        hold_n = 1'b0;
        wclk(4);
        check("R5 no hold while clock high", hold_active, 1'b0);
        check("R5 oe kept while pending", miso_oe, 1'b1);
        sclk = 1'b0;
        wclk(4);
        check("R5 hold after clock low", hold_active, 1'b1);
        sclk = 1'b1;
        wclk(4);
        hold_n = 1'b1;
        wclk(4);
        check("R6 exit deferred", hold_active, 1'b1);
        sclk = 1'b0;
        wclk(4);
        check("R6 exit after clock low", hold_active, 1'b0);
        for (int i = 3; i >= 0; i--) bit_clk(d[i]);
        check("R5 miso intact", miso_acc, 8'h3E);
        deselect();

        // cancelled entry
        select(8'hE1);
        d = 8'h0F;
        exp_rx.push_back(d);
        for (int i = 7; i >= 6; i--) bit_clk(d[i]);
        mosi = d[5];
        wclk(4);
        miso_acc = {miso_acc[6:0], miso_out};
        sclk = 1'b1;
        wclk(2);
        hold_n = 1'b0;
        wclk(2);
        hold_n = 1'b1;
        wclk(4);
        sclk = 1'b0;
        wclk(4);
        check("R7 no pause after cancel", hold_active, 1'b0);
        check("R7 oe kept", miso_oe, 1'b1);
        for (int i = 4; i >= 0; i--) bit_clk(d[i]);
        check("R7 miso intact", miso_acc, 8'hE1);
        deselect();

        // deselect during pause, stale hold level, fresh restart
        select(8'h55);
        for (int i = 0; i < 3; i++) bit_clk(1'b1);
        hold_n = 1'b0;
        wclk(5);
        check("R9 hold before deselect", hold_active, 1'b1);
        cs_n = 1'b1;
        wclk(5);
        check("R9 hold cleared", hold_active, 1'b0);
        check("R9 oe off", miso_oe, 1'b0);
        cs_n = 1'b0;
        wclk(6);
        check("R10 oe off when blocked", miso_oe, 1'b0);
        check("R10 no hold from stale level", hold_active, 1'b0);
        rc = rx_count;
        for (int i = 0; i < 8; i++) bit_clk(i[0]);
        wclk(6);
        check("R10 no byte when blocked", rx_count, rc);
        cs_n = 1'b1;
        wclk(4);
        hold_n = 1'b1;
        wclk(4);
        select(8'hC8);
        send_byte(8'h9D, 8'hC8, 8'h00);
        deselect();

        wclk(10);
        check("R1 all bytes received", exp_rx.size(), 0);
        $display("  [TB] %0d tests run, %0d failed", tests, failed);
        $finish;
    end
endmodule